// File: doc/BRIEF.md
# Short-Address DMA Channel with Repeat

This block is one DMA channel that moves a byte or a 16-bit word between a stepping memory pointer and a fixed I/O pointer. Each accepted activation request produces exactly one transfer. A transfer is one read on a simple bus-master port, followed by one write. The direction bit decides which pointer is read and which one is written. After each transfer the memory pointer moves up or down by the data size, and a transfer counter counts down.

Three operating styles come from two control bits. Normal mode stops the channel when the count runs out. Repeat mode reloads the memory pointer and the count from copies taken when the channel was started, and keeps running. Idle mode holds the memory pointer still and stops at the end of the count with an interrupt. Software programs the channel through a small register port. It must see the enable bit at 0 before it writes it to 1. One of sixteen request lines is chosen as the activation source.

Top module: `sadma_short_chan`

## Requirements
- R1: After reset every register reads 0, the bus is idle (`bus_req` = 0), `irq` = 0 and `req_ack` = 0.
- R2: Register map by `cfg_addr`: 0 memory pointer, 1 I/O pointer, 2 count, 3 control, 4 enable (bit0 enable, bit1 end flag, read-only). Each transfer reads the source and then writes the destination on the next cycle. With control bit3 = 0 the memory pointer is the source and the I/O pointer the destination; with bit3 = 1 the roles swap.
- R3: Control bit0 selects the size. At 0 one byte moves (`bus_wdata[7:0]`, upper byte 0). At 1 a 16-bit word moves, low byte at the even address.
- R4: After every transfer in normal and repeat modes the memory pointer moves by 1 (byte) or 2 (word): up when control bit1 = 0, down when it is 1. The I/O pointer never changes.
- R5: The count register decreases by one for each transfer.
- R6: Normal mode (control bit2 = 0): the transfer that brings the count to 0 clears the enable bit and sets the end flag. Later requests move no data. `irq` equals the end flag ANDed with control bit8.
- R7: Repeat mode (bit2 = 1, bit8 = 0): when the count runs out, the memory pointer and the count return to the values they held when enable was written to 1. The channel stays enabled and `irq` stays 0.
- R8: Idle mode (bit2 = 1, bit8 = 1): the memory pointer never moves. At the end of the count the channel disables itself and raises `irq`.
- R9: Control bits 7:4 select the request line. Pulses on any other line have no effect.
- R10: Requests that arrive while a transfer is running are queued, up to 2^PW-1 of them, and each one is served in turn.
- R11: When control bit9 = 1, `req_ack` pulses for one cycle on the selected line, during the write cycle of each transfer. When bit9 = 0, `req_ack` stays 0.
- R12: While control bit10 (full-address mode) is 1, requests are ignored and pending ones are dropped. Only short-address operation runs.
- R13: Writing 1 to enable while it is 0 starts the channel, captures the reload copies and clears the end flag. Writing 0 stops the channel and drops pending requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | AW | Register write data |
| cfg_rdata | output | AW | Register read data (combinational) |
| req | input | 16 | Activation request lines, one per source |
| req_ack | output | 16 | Request clear pulse, one-hot |
| bus_req | output | 1 | Bus cycle active |
| bus_we | output | 1 | Bus cycle is a write |
| bus_word | output | 1 | Bus cycle is word size |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data, valid in the read cycle |
| irq | output | 1 | Transfer-end interrupt |

## Verification
The bench sweeps every combination of the three modes, both sizes, both step directions and both transfer directions. Each run issues two more requests than the count, so it crosses the end of the count. A design that reloaded at the wrong time would show a pointer off by one step. A design that kept running in normal mode would write bytes that a shadow memory shows must stay untouched. A design that stepped in idle mode would move the pointer away from its base. Directed cases check that a burst of back-to-back requests is not lost and that non-selected lines are ignored. They also check that the full-address bit blocks transfers and that the end flag clears on restart.

// File: rtl/sadma_pkg.sv
// Shared definitions for the short-address DMA channel.
// Assumes the register port is at least 11 bits wide so the control word fits.
package sadma_pkg;
    localparam int SRC_W = 4;
    localparam int NSRC  = 1 << SRC_W;

    localparam logic [2:0] REG_MEMPTR = 3'd0;
    localparam logic [2:0] REG_IOPTR  = 3'd1;
    localparam logic [2:0] REG_COUNT  = 3'd2;
    localparam logic [2:0] REG_CTRL   = 3'd3;
    localparam logic [2:0] REG_ENABLE = 3'd4;

    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_READ  = 2'd1,
        XS_WRITE = 2'd2
    } xfer_state_t;

    typedef struct packed {
        logic             full_mode;  // bit10
        logic             ack_en;     // bit9
        logic             irq_en;     // bit8
        logic [SRC_W-1:0] src;        // bits7:4
        logic             io2mem;     // bit3
        logic             repeat_en;  // bit2
        logic             step_down;  // bit1
        logic             word;       // bit0
    } ctrl_t;
endpackage

// File: rtl/sadma_regs.sv
// Register file and pointer/count update logic for the DMA channel.
// Assumes a software write in the same cycle as a transfer completion
// takes priority over the update caused by that completion.
module sadma_regs
    import sadma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [2:0]    cfg_addr,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] cfg_rdata,
    input  logic          xfer_done,
    output ctrl_t         ctrl,
    output logic [AW-1:0] mem_ptr,
    output logic [AW-1:0] io_ptr,
    output logic          en,
    output logic          irq
);
    logic [CW-1:0] count, count_init;
    logic [AW-1:0] mem_init;
    logic          end_flag;
    logic          last, is_idle, is_rpt;
    logic [AW-1:0] step, next_ptr;

    // Mode decode and next memory pointer.
    always_comb begin
        last     = (count == CW'(1));
        is_idle  = ctrl.repeat_en && ctrl.irq_en;
        is_rpt   = ctrl.repeat_en && !ctrl.irq_en;
        step     = ctrl.word ? AW'(2) : AW'(1);
        next_ptr = ctrl.step_down ? mem_ptr - step : mem_ptr + step;
    end

    // Register state: transfer updates first, software writes override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count      <= '0;
            count_init <= '0;
            mem_ptr    <= '0;
            mem_init   <= '0;
            io_ptr     <= '0;
            ctrl       <= '0;
            en         <= 1'b0;
            end_flag   <= 1'b0;
        end else begin
            if (xfer_done) begin
                if (!is_idle) mem_ptr <= next_ptr;
                count <= count - CW'(1);
                if (last) begin
                    if (is_rpt) begin
                        mem_ptr <= mem_init;
                        count   <= count_init;
                    end else begin
                        en       <= 1'b0;
                        end_flag <= 1'b1;
                    end
                end
            end
            if (cfg_wr) begin
                case (cfg_addr)
                    REG_MEMPTR: mem_ptr <= cfg_wdata;
                    REG_IOPTR:  io_ptr  <= cfg_wdata;
                    REG_COUNT:  count   <= cfg_wdata[CW-1:0];
                    REG_CTRL:   ctrl    <= ctrl_t'(cfg_wdata[10:0]);
                    REG_ENABLE: begin
                        if (!cfg_wdata[0]) begin
                            en <= 1'b0;
                        end else if (!en) begin
                            en         <= 1'b1;
                            end_flag   <= 1'b0;
                            mem_init   <= mem_ptr;
                            count_init <= count;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Interrupt output.
    assign irq = end_flag && ctrl.irq_en;

    // Register read-back multiplexer.
    always_comb begin
        case (cfg_addr)
            REG_MEMPTR: cfg_rdata = mem_ptr;
            REG_IOPTR:  cfg_rdata = io_ptr;
            REG_COUNT:  cfg_rdata = AW'(count);
            REG_CTRL:   cfg_rdata = AW'(ctrl);
            REG_ENABLE: cfg_rdata = AW'({end_flag, en});
            default:    cfg_rdata = '0;
        endcase
    end

    // R6: a normal-mode final transfer disables the channel.
    a_r6_normal_stops: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done && en && !ctrl.repeat_en && last |=> !en);
    // R7: a repeat-mode transfer never disables the channel by itself.
    a_r7_repeat_keeps_en: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done && en && is_rpt && !(cfg_wr && cfg_addr == REG_ENABLE) |=> en);
    // R8: idle mode holds the memory pointer.
    a_r8_idle_ptr_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done && is_idle && !(cfg_wr && cfg_addr == REG_MEMPTR) |=> $stable(mem_ptr));
endmodule

// File: rtl/sadma_reqq.sv
// Activation source selection and pending-request counter.
// Assumes one request per cycle at most on the selected line; the
// counter saturates at 2^PW-1 and is cleared whenever the channel is not armed.
module sadma_reqq
    import sadma_pkg::*;
#(
    parameter int PW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  req,
    input  logic [SRC_W-1:0] src,
    input  logic             armed,
    input  logic             take,
    output logic             have_req
);
    logic [PW-1:0] pend;
    logic          hit, inc;

    // Request hit and increment decision.
    always_comb begin
        hit = armed && req[src];
        inc = hit && ((pend != '1) || take);
    end

    // Pending counter: one up per request, one down per started transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed) pend <= '0;
        else if (inc && !take) pend <= pend + PW'(1);
        else if (take && !inc) pend <= pend - PW'(1);
    end

    assign have_req = armed && (pend != '0);

    // R10: a transfer is started only against a queued request.
    a_r10_take_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> pend != '0);
endmodule

// File: rtl/sadma_xfer.sv
// Transfer sequencer: one read cycle, then one write cycle, per request.
// Assumes the bus returns read data in the same cycle as the read request.
module sadma_xfer
    import sadma_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          have_req,
    input  logic          io2mem,
    input  logic          word,
    input  logic [AW-1:0] mem_ptr,
    input  logic [AW-1:0] io_ptr,
    input  logic [15:0]   bus_rdata,
    output logic          take,
    output logic          done,
    output logic          bus_req,
    output logic          bus_we,
    output logic          bus_word,
    output logic [AW-1:0] bus_addr,
    output logic [15:0]   bus_wdata
);
    xfer_state_t state;
    logic [15:0] data_q;

    // Sequencer state and read-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= XS_IDLE;
            data_q <= '0;
        end else begin
            case (state)
                XS_IDLE:  if (have_req) state <= XS_READ;
                XS_READ: begin
                    state  <= XS_WRITE;
                    data_q <= word ? bus_rdata : {8'h00, bus_rdata[7:0]};
                end
                default:  state <= XS_IDLE;
            endcase
        end
    end

    // Bus drive and handshake strobes.
    always_comb begin
        take      = (state == XS_IDLE) && have_req;
        done      = (state == XS_WRITE);
        bus_req   = (state != XS_IDLE);
        bus_we    = (state == XS_WRITE);
        bus_word  = word;
        bus_wdata = data_q;
        if (state == XS_WRITE) bus_addr = io2mem ? mem_ptr : io_ptr;
        else                   bus_addr = io2mem ? io_ptr : mem_ptr;
    end

    // R2: every read cycle is followed by a write cycle.
    a_r2_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_we |=> bus_req && bus_we);
endmodule

// File: rtl/sadma_short_chan.sv
// Top of the short-address DMA channel with normal, repeat and idle modes.
// Assumes AW >= 11 and a single-cycle bus slave.
module sadma_short_chan
    import sadma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8,
    parameter int PW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [2:0]      cfg_addr,
    input  logic [AW-1:0]   cfg_wdata,
    output logic [AW-1:0]   cfg_rdata,
    input  logic [NSRC-1:0] req,
    output logic [NSRC-1:0] req_ack,
    output logic            bus_req,
    output logic            bus_we,
    output logic            bus_word,
    output logic [AW-1:0]   bus_addr,
    output logic [15:0]     bus_wdata,
    input  logic [15:0]     bus_rdata,
    output logic            irq
);
    ctrl_t         ctrl;
    logic [AW-1:0] mem_ptr, io_ptr;
    logic          en, armed, have_req, take, done;

    sadma_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .xfer_done(done),
        .ctrl(ctrl), .mem_ptr(mem_ptr), .io_ptr(io_ptr), .en(en), .irq(irq)
    );

    assign armed = en && !ctrl.full_mode;

    sadma_reqq #(.PW(PW)) u_reqq (
        .clk(clk), .rst_n(rst_n), .req(req), .src(ctrl.src),
        .armed(armed), .take(take), .have_req(have_req)
    );

    sadma_xfer #(.AW(AW)) u_xfer (
        .clk(clk), .rst_n(rst_n), .have_req(have_req), .io2mem(ctrl.io2mem),
        .word(ctrl.word), .mem_ptr(mem_ptr), .io_ptr(io_ptr),
        .bus_rdata(bus_rdata), .take(take), .done(done), .bus_req(bus_req),
        .bus_we(bus_we), .bus_word(bus_word), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata)
    );

    // Request clear pulse on the selected source at each completion.
    for (genvar g = 0; g < NSRC; g++) begin : g_ack
        assign req_ack[g] = done && ctrl.ack_en && (ctrl.src == SRC_W'(g));
    end

    // R11: at most one clear line at a time, only in a write cycle.
    a_r11_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ack));
    a_r11_ack_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ack != '0) |-> bus_we);
endmodule

// File: tb/test_sadma_short_chan.sv
module test_sadma_short_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [15:0] req = '0;
    logic [15:0] req_ack;
    logic        bus_req, bus_we, bus_word, irq;
    logic [15:0] bus_addr, bus_wdata, bus_rdata;

    logic [7:0] mem  [256];
    logic [7:0] smem [256];
    int checks = 0, errors = 0, ack_total = 0, ack_bad = 0;
    logic [15:0] ack_expect = '0;
    bit finished = 0;

    always #5 clk = ~clk;

    sadma_short_chan i_sadma_short_chan (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req(req), .req_ack(req_ack),
        .bus_req(bus_req), .bus_we(bus_we), .bus_word(bus_word), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Single-cycle memory model, little-endian words.
    assign bus_rdata = bus_word ? {mem[8'(bus_addr[7:0] + 8'd1)], mem[bus_addr[7:0]]}
                                : {8'h00, mem[bus_addr[7:0]]};
    always @(posedge clk) begin
        if (bus_req && bus_we) begin
            mem[bus_addr[7:0]] <= bus_wdata[7:0];
            if (bus_word) mem[8'(bus_addr[7:0] + 8'd1)] <= bus_wdata[15:8];
        end
    end
    always @(negedge clk) begin
        if (req_ack != '0) begin
            ack_total++;
            if (req_ack != ack_expect) ack_bad++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic pulse(input int src, input int n);
        @(negedge clk);
        req[src] = 1'b1;
        repeat (n) @(negedge clk);
        req = '0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input logic [15:0] p, input logic [15:0] io,
                         input logic [15:0] n, input logic [15:0] c);
        logic [15:0] v;
        wr(3'd4, 16'h0); wr(3'd0, p); wr(3'd1, io); wr(3'd2, n); wr(3'd3, c);
        rd(3'd4, v);
        chk("R13 enable reads 0 before start", 32'(v[0]), 0);
        wr(3'd4, 16'h1);
    endtask

    task automatic fill();
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i) ^ 8'h5A;
            smem[i] = 8'(i) ^ 8'h5A;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, base, io, step, eptr, ecnt, ctrl;
        int mode, word, down, io2mem, n, src, irqen, done_n, r, mism;
        bit performed, een, etend;
        logic [7:0] a, sa, da;

        fill();
        settle(3);
        rst_n = 1'b1;
        // R1: reset state
        for (int i = 0; i < 5; i++) begin
            rd(3'(i), v);
            chk($sformatf("R1 reg %0d after reset", i), 32'(v), 0);
        end
        chk("R1 bus idle after reset", 32'(bus_req), 0);
        chk("R1 irq after reset", 32'(irq), 0);
        chk("R1 req_ack after reset", 32'(req_ack), 0);

        // Sweep: mode x size x step direction x transfer direction (R2..R8)
        for (int cfg = 0; cfg < 24; cfg++) begin
            mode = cfg % 3; word = (cfg / 3) % 2; down = (cfg / 6) % 2;
            io2mem = (cfg / 12) % 2; n = 3; src = cfg % 16;
            base = down ? 16'h0080 : 16'h0040; io = 16'h0010;
            step = word ? 16'd2 : 16'd1;
            irqen = (mode == 2) ? 1 : ((mode == 1) ? 0 : down);
            ctrl = 16'((irqen << 8) | (src << 4) | (io2mem << 3) |
                       ((mode != 0) << 2) | (down << 1) | word);
            fill();
            setup(base, io, 16'(n), ctrl);
            for (int k = 0; k < n + 2; k++) begin
                if (io2mem != 0) begin
                    mem[io[7:0]] = 8'hC0 + 8'(k); smem[io[7:0]] = 8'hC0 + 8'(k);
                    mem[io[7:0] + 8'd1] = 8'h30 + 8'(k); smem[io[7:0] + 8'd1] = 8'h30 + 8'(k);
                end
                performed = (mode == 1) || (k < n);
                if (performed) begin
                    r = (mode == 1) ? (k % n) : k;
                    a = (mode == 2) ? base[7:0]
                      : (down != 0 ? 8'(base - 16'(r) * step) : 8'(base + 16'(r) * step));
                    sa = io2mem != 0 ? io[7:0] : a;
                    da = io2mem != 0 ? a : io[7:0];
                    smem[da] = smem[sa];
                    if (word != 0) smem[8'(da + 8'd1)] = smem[8'(sa + 8'd1)];
                end
                pulse(src, 1);
                settle(8);
                mism = 0;
                for (int i = 0; i < 256; i++) if (mem[i] !== smem[i]) mism++;
                chk($sformatf("R2 R3 R6 memory image cfg %0d req %0d", cfg, k), 32'(mism), 0);
                if (mode == 1) begin
                    r = (k + 1) % n;
                    eptr = down != 0 ? base - 16'(r) * step : base + 16'(r) * step;
                    ecnt = (r == 0) ? 16'(n) : 16'(n - r);
                    een = 1; etend = 0;
                end else begin
                    done_n = (k + 1 < n) ? k + 1 : n;
                    if (mode == 2) eptr = base;
                    else eptr = down != 0 ? base - 16'(done_n) * step : base + 16'(done_n) * step;
                    ecnt = 16'(n - done_n);
                    een = (done_n < n); etend = !een;
                end
                rd(3'd0, v);
                chk($sformatf("R4 R7 R8 memory pointer cfg %0d req %0d", cfg, k), 32'(v), 32'(eptr));
                rd(3'd2, v);
                chk($sformatf("R5 R7 count cfg %0d req %0d", cfg, k), 32'(v), 32'(ecnt));
                rd(3'd1, v);
                chk($sformatf("R4 io pointer fixed cfg %0d req %0d", cfg, k), 32'(v), 32'(io));
                rd(3'd4, v);
                chk($sformatf("R6 R7 R8 enable/end flag cfg %0d req %0d", cfg, k),
                    32'(v), 32'({etend, een}));
                chk($sformatf("R6 R8 irq cfg %0d req %0d", cfg, k), 32'(irq), 32'(etend && irqen != 0));
            end
        end
        chk("R11 no clear pulses with bit9 = 0", 32'(ack_total), 0);

        // R9 and R11: source select and request clear
        fill();
        ack_total = 0; ack_bad = 0; ack_expect = 16'h0020;
        setup(16'h0040, 16'h0010, 16'd4, 16'h0350);
        pulse(3, 1); settle(8);
        rd(3'd2, v);
        chk("R9 other source ignored", 32'(v), 4);
        pulse(5, 1); settle(8);
        rd(3'd2, v);
        chk("R9 selected source served", 32'(v), 3);
        chk("R11 one clear pulse", 32'(ack_total), 1);
        chk("R11 clear pulse on selected line", 32'(ack_bad), 0);

        // R10: back-to-back burst is queued, none lost
        ack_total = 0;
        setup(16'h0040, 16'h0010, 16'd4, 16'h0350);
        pulse(5, 4); settle(20);
        rd(3'd2, v);
        chk("R10 burst count", 32'(v), 0);
        rd(3'd0, v);
        chk("R10 burst pointer", 32'(v), 32'h44);
        rd(3'd4, v);
        chk("R10 R6 stopped after burst", 32'(v), 2);
        chk("R6 irq raised", 32'(irq), 1);
        chk("R11 one pulse per burst transfer", 32'(ack_total), 4);

        // R12 and R13: full-address bit blocks, restart clears end flag
        setup(16'h0040, 16'h0010, 16'd4, 16'h0550);
        chk("R13 restart clears irq", 32'(irq), 0);
        pulse(5, 1); settle(8);
        rd(3'd2, v);
        chk("R12 full-address mode ignores request", 32'(v), 4);
        wr(3'd3, 16'h0150);
        pulse(5, 1); settle(8);
        rd(3'd2, v);
        chk("R12 short mode serves request", 32'(v), 3);
        wr(3'd4, 16'h0);
        pulse(5, 1); settle(8);
        rd(3'd2, v);
        chk("R13 disabled channel ignores request", 32'(v), 3);
        rd(3'd4, v);
        chk("R13 enable cleared by write", 32'(v), 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule